// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a single programmable interval timer that is controlled through a small synchronous register port. Software loads a start value into the count register and sets the enable bit. From then on the count drops by one on each tick of a free-running prescaler, and a 2-bit field in the mode register picks the prescaler rate.

The timer has two modes. In one-shot mode it stops on its own at zero and latches a terminal-count flag, which software can poll. In auto-reload mode it refills the count from the reload register and keeps running. Each time the count reaches zero, in either mode, a single-cycle interrupt pulse is raised.

The register port is combinational on reads and acts on the clock edge for writes. Address 0 selects the mode register, address 1 the count register and address 2 the reload register. Any access to address 0, read or write, consumes the terminal-count flag.

Top module: `ivt_timer`

## Requirements
- R1: After reset, all three registers read back as zero and the interrupt output is low. This covers the mode register, the count register (address 1) and the reload register (address 2).
- R2: The mode register layout at address 0 is: bit 0 terminal-count flag, bit 1 enable, bit 2 auto-reload, bits 4:3 clock select, all other bits zero. A write updates bits 1 to 4 and ignores the value written to bit 0.
- R3: While enable is set, each prescaler tick lowers a nonzero count by exactly one.
- R4: The clock-select field gives a tick on every clock for 0, every 4th clock for 1, every 16th clock for 2 and every 64th clock for 3. The ticks are taken from a prescaler that runs freely from reset, and a tick occurs when the prescaler's low 0, 2, 4 or 6 bits are all zero.
- R5: While enable is clear, the count holds its value and ticks are ignored.
- R6: With auto-reload clear, the tick that takes the count from 1 to 0 sets the terminal-count flag and clears enable. A tick while enabled at count 0 also clears enable, but it does not set the flag.
- R7: Any read or write access to address 0 clears the terminal-count flag. If that access falls in the same cycle as a flag-setting event, the flag is set and the event is not lost.
- R8: With auto-reload and enable both set, a tick at count 0 loads the count from the reload register. Enable stays set and the terminal-count flag is not set.
- R9: In auto-reload mode with a reload value of zero, the count stays at zero and no further interrupt pulses occur.
- R10: The interrupt output is high for exactly one cycle, the first cycle in which the count reads zero after a tick took it from 1 to 0. This holds in both modes.
- R11: A write to the count register or the reload register stores the written value. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write when high, a read when low |
| reg_addr | input | 2 | Register select: 0 mode, 1 count, 2 reload |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for the register at reg_addr |
| irq | output | 1 | One-cycle terminal-count pulse |

## Verification
A behavioural reference model is checked against the read data and the interrupt output on every clock.

- One-shot runs at full rate show whether the flag and the self-clearing enable fall on the exact 1-to-0 tick.
- Long runs at each of the three slower clock selects separate the correct prescaler phase and divider from an off-by-one tick.
- Auto-reload runs with a nonzero reload value, and then with the reload value changed to zero, distinguish reload-at-zero from a stall.
- A mode read placed in the very cycle of terminal count shows whether the flag set wins over the clear.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [1:0] {
      ADDR_MODE   = 2'd0,
      ADDR_COUNT  = 2'd1,
      ADDR_RELOAD = 2'd2,
      ADDR_NONE   = 2'd3
   } ivt_addr_e;

   localparam int SEL_W  = 2;
   localparam int MODE_W = 3 + SEL_W;

   typedef struct packed {
      logic [SEL_W-1:0] csel;
      logic             auto_rl;
      logic             enable;
      logic             tc;
   } ivt_mode_t;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int SEL_W = 2,
   parameter int STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] csel,
   output logic             tick
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int PRE_W = STEP * (NSEL - 1);

   if (SEL_W < 1 || STEP < 1) begin : g_bad_cfg
      $error("ivt_prescaler: SEL_W and STEP must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NSEL-1:0]  opt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_opt
      if (i == 0) begin : g_full
         assign opt[i] = 1'b1;
      end else begin : g_div
         assign opt[i] = (pre_q[i*STEP-1:0] == '0);
      end
   end

   assign tick = opt[csel];
endmodule

// File: rtl/ivt_down_counter.sv
module ivt_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             auto_rl,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt,
   output logic             stop_req
);
   logic [CNT_W-1:0] count_q;
   logic             active;
   logic             at_one;
   logic             at_zero;

   assign active  = tick && enable && !load_en;
   assign at_one  = (count_q == CNT_W'(1));
   assign at_zero = (count_q == '0);

   assign zero_evt = active && at_one;
   assign stop_req = active && !auto_rl && (at_one || at_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load_en) begin
         count_q <= load_val;
      end else if (active) begin
         if (!at_zero)     count_q <= count_q - 1'b1;
         else if (auto_rl) count_q <= reload_val;
      end
   end

   assign count = count_q;
endmodule

// File: rtl/ivt_mode_reg.sv
module ivt_mode_reg
   import ivt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_acc,
   input  logic      mode_wr,
   input  ivt_mode_t wr_val,
   input  logic      zero_evt,
   input  logic      stop_req,
   output ivt_mode_t mode
);
   ivt_mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else begin
         if (mode_wr) begin
            mode_q.enable  <= wr_val.enable;
            mode_q.auto_rl <= wr_val.auto_rl;
            mode_q.csel    <= wr_val.csel;
         end else if (stop_req) begin
            mode_q.enable  <= 1'b0;
         end
         if (zero_evt && !mode_q.auto_rl) mode_q.tc <= 1'b1;
         else if (mode_acc)               mode_q.tc <= 1'b0;
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("ivt_timer: CNT_W must lie in 2..DATA_W");
   end
   if (MODE_W > DATA_W) begin : g_bad_data
      $error("ivt_timer: DATA_W too narrow for the mode register");
   end

   logic             mode_acc, mode_wr, cnt_wr, rld_wr;
   logic             tick, zero_evt, stop_req;
   logic [CNT_W-1:0] count, reload_q;
   logic             irq_q;
   ivt_mode_t        mode, wr_mode;

   assign mode_acc = reg_en && (reg_addr == ADDR_MODE);
   assign mode_wr  = mode_acc && reg_wr;
   assign cnt_wr   = reg_en && reg_wr && (reg_addr == ADDR_COUNT);
   assign rld_wr   = reg_en && reg_wr && (reg_addr == ADDR_RELOAD);
   assign wr_mode  = reg_wdata[MODE_W-1:0];

   ivt_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
      .clk(clk), .rst_n(rst_n), .csel(mode.csel), .tick(tick)
   );

   ivt_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .mode_acc(mode_acc), .mode_wr(mode_wr),
      .wr_val(wr_mode), .zero_evt(zero_evt), .stop_req(stop_req), .mode(mode)
   );

   ivt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(mode.enable),
      .auto_rl(mode.auto_rl), .reload_val(reload_q), .load_en(cnt_wr),
      .load_val(reg_wdata[CNT_W-1:0]), .count(count),
      .zero_evt(zero_evt), .stop_req(stop_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (rld_wr) reload_q <= reg_wdata[CNT_W-1:0];
         irq_q <= zero_evt;
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADDR_MODE:   reg_rdata = DATA_W'(mode);
         ADDR_COUNT:  reg_rdata = DATA_W'(count);
         ADDR_RELOAD: reg_rdata = DATA_W'(reload_q);
         default:     reg_rdata = '0;
      endcase
   end

   assign irq = irq_q;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             tick,
   input logic             enable,
   input logic             auto_rl,
   input logic             tc,
   input logic             mode_acc,
   input logic             mode_wr,
   input logic             cnt_wr,
   input logic             rld_wr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload
);
   logic fire_one;
   assign fire_one = tick && enable && !cnt_wr && (count == CNT_W'(1));

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);                                                       // R10
   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (count == '0));                                              // R10
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cnt_wr) |=> $stable(count));                            // R5
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && enable && !cnt_wr && count > CNT_W'(1)) |=>
      (count == $past(count) - 1'b1));                                     // R3
   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_one && !auto_rl && !mode_wr) |=> (!enable && tc));             // R6
   AST_TC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_acc && !(fire_one && !auto_rl)) |=> !tc);                      // R7
   AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && enable && auto_rl && count == '0 && !cnt_wr && !rld_wr && !mode_wr)
      |=> (count == $past(reload) && enable));                             // R8
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .tick(tick),
   .enable(mode.enable), .auto_rl(mode.auto_rl), .tc(mode.tc),
   .mode_acc(mode_acc), .mode_wr(mode_wr), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
   .count(count), .reload(reload_q)
);

// File: tb/ivt_timer_bench.sv
`timescale 1ns/1ps
module ivt_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_en = 1'b0, reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        irq;

   int    n_checks = 0, n_errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   int m_pre, m_cnt, m_rld, m_en, m_au, m_tc, m_csel, m_irq, irq_seen;

   always #2.5 clk = ~clk;

   ivt_timer u_ivt_timer (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_rd(input int a);
      case (a)
         0: return m_tc | (m_en << 1) | (m_au << 2) | (m_csel << 3);
         1: return m_cnt;
         2: return m_rld;
         default: return 0;
      endcase
   endfunction

   // reference model, evaluated on the inputs applied for the ending cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_rld = 0; m_en = 0; m_au = 0; m_tc = 0;
         m_csel = 0; m_irq = 0;
      end else begin
         int tick, cw, rw, mw, ma, act, zero, stop, n_cnt, n_en;
         tick = ((m_pre % (1 << (2 * m_csel))) == 0);
         ma   = reg_en && reg_addr == 0;
         mw   = ma && reg_wr;
         cw   = reg_en && reg_wr && reg_addr == 1;
         rw   = reg_en && reg_wr && reg_addr == 2;
         act  = tick && m_en && !cw;
         zero = act && m_cnt == 1;
         stop = act && !m_au && m_cnt <= 1;
         n_cnt = m_cnt;
         if (cw) n_cnt = reg_wdata;
         else if (act) begin
            if (m_cnt != 0) n_cnt = m_cnt - 1;
            else if (m_au)  n_cnt = m_rld;
         end
         n_en = mw ? int'(reg_wdata[1]) : (stop ? 0 : m_en);
         if (zero && !m_au) m_tc = 1;
         else if (ma)       m_tc = 0;
         if (mw) begin
            m_au   = reg_wdata[2];
            m_csel = reg_wdata[4:3];
         end
         if (rw) m_rld = reg_wdata;
         m_en  = n_en;
         m_cnt = n_cnt;
         m_irq = zero;
         m_pre = (m_pre + 1) % 64;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, reg_rdata, model_rd(reg_addr));
         check("R10", irq, m_irq);
         if (irq) irq_seen++;
      end
   end

   task automatic op(input logic en, input logic wr, input logic [1:0] a,
                     input logic [15:0] d);
      @(posedge clk); #1;
      reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = d;
   endtask

   task automatic idle(input logic [1:0] a, input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, a, 16'd0);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset values
      cur_req = "R1";
      for (int a = 0; a < 3; a++) begin
         idle(a[1:0], 1); @(negedge clk); check("R1", reg_rdata, 0);
      end
      check("R1", irq, 0);

      // R2 / R3 / R6: one-shot run at full rate
      cur_req = "R11";
      op(1, 1, 1, 16'd6);
      op(1, 1, 2, 16'd4);
      cur_req = "R2";
      op(1, 1, 0, 16'h0003);          // bit 0 ignored
      idle(0, 1); @(negedge clk); check("R2", reg_rdata, 16'h0002);
      cur_req = "R3";
      idle(1, 8);
      cur_req = "R6";
      idle(0, 2); @(negedge clk); check("R6", reg_rdata, 16'h0001);
      // R7: read access clears the flag
      cur_req = "R7";
      op(1, 0, 0, 16'd0);
      idle(0, 1); @(negedge clk); check("R7", reg_rdata, 16'h0000);

      // R5: disabled timer holds count
      cur_req = "R5";
      op(1, 1, 1, 16'd9);
      idle(1, 12); @(negedge clk); check("R5", reg_rdata, 9);

      // R4: slower clock selects
      cur_req = "R4";
      for (int s = 1; s < 4; s++) begin
         op(1, 1, 1, 16'd200);
         op(1, 1, 0, 16'(2 | (s << 3)));
         idle(1, 300);
      end
      op(1, 1, 0, 16'h0000);

      // R8: auto-reload running
      cur_req = "R8";
      op(1, 1, 2, 16'd3);
      op(1, 1, 1, 16'd2);
      irq_seen = 0;
      op(1, 1, 0, 16'h0006);
      idle(1, 20);
      idle(0, 1); @(negedge clk); check("R8", reg_rdata, 16'h0006);
      check("R8", (irq_seen >= 4) ? 1 : 0, 1);
      // R11: count write while running
      cur_req = "R11";
      op(1, 1, 1, 16'd7);
      idle(1, 5);

      // R9: zero reload value
      cur_req = "R9";
      op(1, 1, 2, 16'd0);
      idle(1, 12);
      irq_seen = 0;
      idle(1, 20); @(negedge clk);
      check("R9", reg_rdata, 0);
      check("R9", irq_seen, 0);
      op(1, 1, 0, 16'h0000);

      // R7: flag set wins over same-cycle read access
      cur_req = "R7";
      op(1, 1, 1, 16'd2);
      op(1, 1, 0, 16'h0002);
      idle(0, 1);
      op(1, 0, 0, 16'd0);             // read in the terminal-count cycle
      idle(0, 1); @(negedge clk); check("R7", reg_rdata, 16'h0001);
      idle(0, 3);

      done = 1'b1;
      finish_run();
   end
endmodule